// File: doc/BRIEF.md
# Five-Port GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for forty pins, grouped as five ports of eight. Each port has four 16-bit registers. The first sets each pin's direction. The second drives the output levels and reads back the synchronised pin levels. The third holds per-pin interrupt mask and edge-select bits. The fourth holds the pending interrupt flags, which software clears by writing ones. All pending flags are ORed into one registered interrupt line.

Software reaches the registers through a simple single-cycle strobe interface. A write takes effect at the clock edge that samples it. Read data is registered and appears in the following cycle. Each pin input passes through a two-flop synchroniser. An edge detector then compares the synchronised level with its value from the previous cycle. If the pin is unmasked and the edge matches the selected direction, the pin's pending flag is set.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After synchronous reset, the following values hold:
  - `bus_rdata`, `irq`, `pin_out` and `pin_oe` are all zero.
  - Every mode and status register reads 0.
  - Every interrupt control register reads 16'h00FF, so all pins are masked with falling edge selected.
- R2: The byte address is laid out as follows:
  - Bits [5:4] select the bank: 00 is mode, 01 is data, 10 is interrupt control, 11 is status.
  - Bits [3:1] select the port.
  - Bit 0 must be 0.
  - Read data appears on `bus_rdata` in the cycle after a read strobe. In every other cycle `bus_rdata` is zero.
- R3: An access is undecoded if its address is odd or names port 5, 6 or 7. An undecoded read returns zero, and an undecoded write changes nothing.
- R4: Pin p of a port has a 2-bit mode field at bits [2p+1:2p] of the mode register. The encodings are:
  - 01 means output, and only then is `pin_oe` high for that pin.
  - 00, 10 and 11 mean input.
  - A write replaces the whole register, and a read returns all 16 bits.
- R5: A data write stores bits [7:0] and drives them on `pin_out`. Pin p of port n uses bit index 8n+p of every pin vector. Bits [15:8] of the write are ignored.
- R6: A data read returns, in bits [7:0], the pin levels after a two-flop synchroniser. The upper byte reads as zero. A pin change made before clock edge k is visible to a read strobe sampled at edge k+2 or later.
- R7: In the interrupt control register, bit p is the mask for pin p: 1 masks the pin and 0 enables it. A masked pin never sets its pending flag.
- R8: In the interrupt control register, bit 8+p selects the edge for pin p: 1 means rising and 0 means falling. An edge is a change in the synchronised level between consecutive cycles. A pin change made before edge k sets the flag at edge k+2.
- R9: In the status register, bits [7:0] are the pending flags. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. The upper byte reads as zero.
- R10: If a flag's set condition and a write-one clear of that flag occur at the same edge, the flag is left set.
- R11: `irq` is registered:
  - It is high in the cycle after any pending flag is set.
  - It is low in the cycle after all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address: bank, port, halfword alignment bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 40 | Asynchronous pin levels, index 8*port+pin |
| pin_out | output | 40 | Output levels from the data registers |
| pin_oe | output | 40 | Output enable, high for pins in output mode |
| irq | output | 1 | Shared interrupt, high while any flag is pending |

## Verification
Some faults in the register state show at the ports one cycle after the write that caused them. A wrong mode or data register appears that way on `pin_oe` or `pin_out`. A wrong interrupt control register does not show itself directly. It appears as a wrong readback, or as a pending flag that fails to set or sets when it should not. Faults in the synchroniser or edge history surface on `irq` three cycles after the pin change, and on a status read one cycle later. The bench runs a behavioural model alongside the design and compares `bus_rdata`, `irq`, `pin_out` and `pin_oe` every cycle, so a divergence is flagged in the cycle it first reaches a port. The set-versus-clear collision is driven on the exact edge where the flag would set.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    BANK_MODE = 2'b00,
    BANK_DATA = 2'b01,
    BANK_ICTL = 2'b10,
    BANK_STAT = 2'b11
  } bank_e;

  typedef enum logic [1:0] {
    PM_IN    = 2'b00,
    PM_OUT   = 2'b01,
    PM_RSV_A = 2'b10,
    PM_RSV_B = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_AW   = 3,
  parameter int ADDR_W    = PORT_AW + 3
) (
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 hit,
  output bank_e                bank,
  output logic [PORT_AW-1:0]   port,
  output logic [NUM_PORTS-1:0] wr_mode,
  output logic [NUM_PORTS-1:0] wr_data,
  output logic [NUM_PORTS-1:0] wr_ictl,
  output logic [NUM_PORTS-1:0] wr_stat
);
  assign port = bus_addr[PORT_AW:1];
  assign bank = bank_e'(bus_addr[ADDR_W-1:ADDR_W-2]);
  assign hit  = bus_sel && !bus_addr[0] && (int'(port) < NUM_PORTS);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strobe
    logic wr_here;
    assign wr_here    = hit && bus_we && (port == PORT_AW'(p));
    assign wr_mode[p] = wr_here && (bank == BANK_MODE);
    assign wr_data[p] = wr_here && (bank == BANK_DATA);
    assign wr_ictl[p] = wr_here && (bank == BANK_ICTL);
    assign wr_stat[p] = wr_here && (bank == BANK_STAT);
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_data,
  input  logic              wr_ictl,
  input  logic              wr_stat,
  input  logic [REG_W-1:0]  wdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [2*PINS-1:0] mode_q,
  output logic [2*PINS-1:0] ictl_q,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   level,
  output logic [PINS-1:0]   stat_q,
  output logic [PINS-1:0]   oe
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] set_vec;
  logic [PINS-1:0] clr_vec;

  pio_sync #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (level)
  );

  assign clr_vec = wr_stat ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      data_q <= '0;
      ictl_q <= {{PINS{1'b0}}, {PINS{1'b1}}};
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= level;
      if (wr_mode) mode_q <= wdata[2*PINS-1:0];
      if (wr_data) data_q <= wdata[PINS-1:0];
      if (wr_ictl) ictl_q <= wdata[2*PINS-1:0];
      // a fresh edge outranks a simultaneous clear
      stat_q <= set_vec | (stat_q & ~clr_vec);
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e fld;
    logic      rise;
    logic      fall;
    logic      hit_edge;
    assign fld      = pin_mode_e'(mode_q[2*i +: 2]);
    assign oe[i]    = (fld == PM_OUT);
    assign rise     = level[i] & ~prev_q[i];
    assign fall     = ~level[i] & prev_q[i];
    assign hit_edge = ictl_q[PINS+i] ? rise : fall;
    assign set_vec[i] = hit_edge & ~ictl_q[i];
  end
endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PINS      = 8,
  parameter int PORT_AW   = $clog2(NUM_PORTS),
  parameter int ADDR_W    = PORT_AW + 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  input  logic [NUM_PORTS*PINS-1:0] pin_in,
  output logic [NUM_PORTS*PINS-1:0] pin_out,
  output logic [NUM_PORTS*PINS-1:0] pin_oe,
  output logic                      irq
);
  localparam int NPIN = NUM_PORTS * PINS;

  logic                 hit;
  bank_e                bank;
  logic [PORT_AW-1:0]   port;
  logic [NUM_PORTS-1:0] wr_mode, wr_data, wr_ictl, wr_stat;

  logic [2*PINS-1:0] mode_a  [NUM_PORTS];
  logic [2*PINS-1:0] ictl_a  [NUM_PORTS];
  logic [PINS-1:0]   data_a  [NUM_PORTS];
  logic [PINS-1:0]   level_a [NUM_PORTS];
  logic [PINS-1:0]   stat_a  [NUM_PORTS];
  logic [NPIN-1:0]   stat_all;
  logic [NPIN-1:0]   mask_all;
  logic [REG_W-1:0]  rd_val;

  pio_decode #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_AW   (PORT_AW),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .hit      (hit),
    .bank     (bank),
    .port     (port),
    .wr_mode  (wr_mode),
    .wr_data  (wr_data),
    .wr_ictl  (wr_ictl),
    .wr_stat  (wr_stat)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio_port #(.PINS(PINS)) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_mode (wr_mode[p]),
      .wr_data (wr_data[p]),
      .wr_ictl (wr_ictl[p]),
      .wr_stat (wr_stat[p]),
      .wdata   (bus_wdata),
      .pin_in  (pin_in[p*PINS +: PINS]),
      .mode_q  (mode_a[p]),
      .ictl_q  (ictl_a[p]),
      .data_q  (data_a[p]),
      .level   (level_a[p]),
      .stat_q  (stat_a[p]),
      .oe      (pin_oe[p*PINS +: PINS])
    );
    assign pin_out[p*PINS +: PINS]  = data_a[p];
    assign stat_all[p*PINS +: PINS] = stat_a[p];
    assign mask_all[p*PINS +: PINS] = ictl_a[p][PINS-1:0];
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit && !bus_we && (port == PORT_AW'(p))) begin
        case (bank)
          BANK_MODE: rd_val = REG_W'(mode_a[p]);
          BANK_DATA: rd_val = REG_W'(level_a[p]);
          BANK_ICTL: rd_val = REG_W'(ictl_a[p]);
          default:   rd_val = REG_W'(stat_a[p]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_val;
      irq       <= |stat_all;
    end
  end
endmodule

// File: rtl/pio_edge_ctrl_chk.sv
module pio_edge_ctrl_chk #(
  parameter int NUM_PORTS = 5,
  parameter int PINS      = 8,
  parameter int REG_W     = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_sel,
  input logic                      bus_we,
  input logic [REG_W-1:0]          bus_rdata,
  input logic [NUM_PORTS*PINS-1:0] pin_out,
  input logic [NUM_PORTS*PINS-1:0] pin_oe,
  input logic                      irq,
  input logic [NUM_PORTS*PINS-1:0] stat_all,
  input logic [NUM_PORTS*PINS-1:0] mask_all
);
  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_all == '1 && pin_oe == '0 && pin_out == '0 && !irq));

  // R2: read data only in the cycle after a read strobe
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));

  // R4: direction changes only after a write
  p_oe_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && bus_we) |-> $stable(pin_oe));

  // R5: output levels change only after a write
  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel && bus_we) |-> $stable(pin_out));

  // R7: a flag never rises on a pin that was masked
  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ((stat_all & ~$past(stat_all) & $past(mask_all)) == '0));

  // R11: irq follows the pending flags one cycle later
  p_irq_set_r11: assert property (@(posedge clk) disable iff (rst)
    (|stat_all) |=> irq);

  p_irq_clr_r11: assert property (@(posedge clk) disable iff (rst)
    !(|stat_all) |=> !irq);
endmodule

bind pio_edge_ctrl pio_edge_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PINS      (PINS),
  .REG_W     (pio_pkg::REG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_all  (stat_all),
  .mask_all  (mask_all)
);

// File: tb/sim_pio_edge_ctrl.sv
module sim_pio_edge_ctrl;
  localparam int NP   = 5;
  localparam int PN   = 8;
  localparam int NPIN = NP * PN;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_sel = 1'b0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out;
  logic [NPIN-1:0] pin_oe;
  logic            irq;

  always #10 clk = ~clk;

  pio_edge_ctrl u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0]     m_mode [NP];
  logic [15:0]     m_ictl [NP];
  logic [7:0]      m_data [NP];
  logic [7:0]      m_stat [NP];
  logic [NPIN-1:0] m_s1, m_s2, m_s3;
  logic [15:0]     m_rd;
  logic            m_irq;

  always @(posedge clk) begin : model
    logic [7:0]  nst [NP];
    logic [15:0] nrd;
    logic        any, up, dn, ev, ck;
    int          pt, idx;
    bit          hit;
    if (rst) begin
      for (int p = 0; p < NP; p++) begin
        m_mode[p] = 16'h0000;
        m_ictl[p] = 16'h00FF;
        m_data[p] = 8'h00;
        m_stat[p] = 8'h00;
      end
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_rd = 16'h0000;
      m_irq = 1'b0;
    end else begin
      pt  = int'(bus_addr[3:1]);
      hit = bus_sel && !bus_addr[0] && (pt < NP);
      nrd = 16'h0000;
      if (hit && !bus_we) begin
        case (bus_addr[5:4])
          2'd0: nrd = m_mode[pt];
          2'd1: nrd = {8'h00, m_s2[pt*8 +: 8]};
          2'd2: nrd = m_ictl[pt];
          default: nrd = {8'h00, m_stat[pt]};
        endcase
      end
      any = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (m_stat[p] != 8'h00) any = 1'b1;
        for (int b = 0; b < PN; b++) begin
          idx = p * 8 + b;
          up  = m_s2[idx] && !m_s3[idx];
          dn  = !m_s2[idx] && m_s3[idx];
          ev  = m_ictl[p][8+b] ? up : dn;
          ck  = hit && bus_we && (bus_addr[5:4] == 2'd3) && (pt == p) && bus_wdata[b];
          nst[p][b] = (ev && !m_ictl[p][b]) || (m_stat[p][b] && !ck);
        end
      end
      m_rd  = nrd;
      m_irq = any;
      for (int p = 0; p < NP; p++) m_stat[p] = nst[p];
      if (hit && bus_we) begin
        case (bus_addr[5:4])
          2'd0: m_mode[pt] = bus_wdata;
          2'd1: m_data[pt] = bus_wdata[7:0];
          2'd2: m_ictl[pt] = bus_wdata;
          default: ;
        endcase
      end
      m_s3 = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin : compare
    logic [NPIN-1:0] eo, eoe;
    if (!rst && !done) begin
      for (int p = 0; p < NP; p++) begin
        for (int b = 0; b < PN; b++) begin
          eo[p*8+b]  = m_data[p][b];
          eoe[p*8+b] = (m_mode[p][2*b +: 2] == 2'b01);
        end
      end
      chk("R2 model bus_rdata", 64'(bus_rdata), 64'(m_rd));
      chk("R11 model irq", 64'(irq), 64'(m_irq));
      chk("R5 model pin_out", 64'(pin_out), 64'(eo));
      chk("R4 model pin_oe", 64'(pin_oe), 64'(eoe));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, 20000);
      wrap_up();
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [AW-1:0] ra(input int bank, input int port);
    return {2'(bank), 3'(port), 1'b0};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
  endtask

  logic [15:0]     v;
  logic [NPIN-1:0] snap_out, snap_oe;

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset values
    chk("R1 pin_oe after reset", 64'(pin_oe), 64'h0);
    chk("R1 pin_out after reset", 64'(pin_out), 64'h0);
    chk("R1 irq after reset", 64'(irq), 64'h0);
    rd(ra(2, 3), v); chk("R1 ictl port3 reset", 64'(v), 64'h00FF);
    rd(ra(3, 3), v); chk("R1 status port3 reset", 64'(v), 64'h0);

    // R2: rdata returns to zero the cycle after the read
    idle(1);
    chk("R2 rdata idle after read", 64'(bus_rdata), 64'h0);

    // R4: mode fields, reserved codes act as inputs
    wr(ra(0, 1), 16'h0079);
    rd(ra(0, 1), v); chk("R4 mode readback", 64'(v), 64'h0079);
    chk("R4 pin_oe port1", 64'(pin_oe[15:8]), 64'h09);

    // R5: data drives pin_out, upper byte ignored
    wr(ra(1, 1), 16'hABCD);
    chk("R5 pin_out vector", 64'(pin_out), 64'h00_0000_CD00);

    // R6: synchronised level readback
    drive_pin(32, 1'b0);
    pin_in[39:32] = 8'h5A;
    idle(3);
    rd(ra(1, 4), v); chk("R6 data port4 level", 64'(v), 64'h005A);

    // R3: undecoded accesses
    snap_out = pin_out; snap_oe = pin_oe;
    wr(ra(1, 5), 16'h00FF);
    wr(6'h03, 16'hFFFF);
    idle(1);
    chk("R3 pin_out unchanged", 64'(pin_out), 64'(snap_out));
    chk("R3 pin_oe unchanged", 64'(pin_oe), 64'(snap_oe));
    rd(ra(1, 5), v); chk("R3 port5 read zero", 64'(v), 64'h0);
    rd(6'h13, v);    chk("R3 odd address read zero", 64'(v), 64'h0);

    // R7: masked pin does not set a flag
    drive_pin(0, 1'b1);
    idle(5);
    rd(ra(3, 0), v); chk("R7 masked edge ignored", 64'(v), 64'h0);
    chk("R7 irq stays low", 64'(irq), 64'h0);

    // R8: rising select on port0 pin0
    wr(ra(2, 0), 16'h01FE);
    drive_pin(0, 1'b0);
    idle(5);
    rd(ra(3, 0), v); chk("R8 falling ignored under rising select", 64'(v), 64'h0);
    drive_pin(0, 1'b1);
    idle(4);
    chk("R11 irq high after flag", 64'(irq), 64'h1);
    rd(ra(3, 0), v); chk("R8 rising edge sets flag", 64'(v), 64'h0001);

    // R9: write-one-to-clear
    wr(ra(3, 0), 16'hFF00);
    rd(ra(3, 0), v); chk("R9 zero write keeps flag", 64'(v), 64'h0001);
    wr(ra(3, 0), 16'h0001);
    rd(ra(3, 0), v); chk("R9 one write clears flag", 64'(v), 64'h0);
    idle(1);
    chk("R11 irq low after clear", 64'(irq), 64'h0);

    // R8: falling select on port2 pin2
    wr(ra(2, 2), 16'h00FB);
    drive_pin(18, 1'b1);
    idle(5);
    rd(ra(3, 2), v); chk("R8 rising ignored under falling select", 64'(v), 64'h0);
    drive_pin(18, 1'b0);
    idle(5);
    rd(ra(3, 2), v); chk("R8 falling edge sets flag", 64'(v), 64'h0004);

    // R10: set wins over a same-edge clear
    drive_pin(18, 1'b1);
    idle(4);
    drive_pin(18, 1'b0);
    @(negedge clk);
    wr(ra(3, 2), 16'h0004);
    rd(ra(3, 2), v); chk("R10 set beats clear", 64'(v), 64'h0004);
    wr(ra(3, 2), 16'h0004);
    rd(ra(3, 2), v); chk("R10 later clear works", 64'(v), 64'h0);
    idle(2);
    chk("R11 irq low at end", 64'(irq), 64'h0);

    idle(2);
    wrap_up();
  end
endmodule